// File: doc/BRIEF.md
# EDO DRAM Controller with Refresh

This block sits between a synchronous host request port and an asynchronous extended-data-out DRAM whose address pins are multiplexed. The host offers one request at a time with valid/ready: a read or write flag, a 20-bit word address, 16 bits of write data and two byte enables. The controller turns each accepted request into row and column strobe sequences on the DRAM pins. It drives the address pins, one row strobe, two byte-lane column strobes, write enable and output enable. It reaches the shared 16-bit data bus through separate output, output-enable and input signals.

After reset the controller waits for the power-up interval and runs the initialization refresh cycles before it offers ready. Once running, it keeps a row open for as long as requests keep hitting it, and it serves those hits as page-mode column cycles. It closes the row on a miss, when a refresh is due, or when the row has been open for its maximum allowed time. A refresh timer schedules column-before-row refresh cycles, and those take priority over new host requests. Every timing figure is a clock-cycle count parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: From reset release, the row strobe and both column strobes stay high and `req_ready` stays low for at least `INIT_WAIT` cycles.
- R2: At least `INIT_REFS` refresh cycles complete before `req_ready` is first high.
- R3: When the row strobe falls for an access, the address pins carry `req_addr[19:10]` and both column strobes are high. When a column strobe falls, the address pins carry `req_addr[9:0]`. Accesses appear on the pins in the order they were accepted.
- R4: `req_be[0]` selects the lower strobe, which gates data bits 7:0. `req_be[1]` selects the upper strobe, which gates bits 15:8. Only selected strobes fall. In `rd_data`, the byte of any lane that was not selected reads as zero.
- R5: For a write, write enable is low in the cycle before the column strobes fall and stays unchanged while they are low. The controller drives the data bus (`dram_dq_oe`=1) with the write data at the falling edge.
- R6: For a read, write enable is high and output enable is low when the column strobes fall. Data is sampled after the strobes rise and returned on a one-cycle `rd_valid` pulse, in request order.
- R7: A request to the row already open is served by a new column cycle with the row strobe held low, so no new row activation occurs.
- R8: A request to a different row closes the open row. Before any row strobe falls, the row strobe has been high for at least `T_RP` cycles.
- R9: In a refresh cycle both column strobes are low at least one cycle before the row strobe falls, and write enable is high. Refresh ticks arrive every `REFI` cycles. A tick that cannot be served at once is counted, up to `DEBT_MAX` outstanding, so that none is lost.
- R10: `req_ready` is low during initialization and whenever any column strobe is low. A pending refresh blocks new requests until it has run.
- R11: For an access, the row strobe stays low for no more than `T_RAS_MAX+T_CP+T_CAS+1` cycles. A long run of hits to one row is split into several activations.
- R12: `dram_dq_oe` and a low output enable are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 16 | Read data, unselected bytes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Column strobe for bits 7:0, active low |
| dram_ucas_n | output | 1 | Column strobe for bits 15:8, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data bus as seen from the DRAM |

## Verification
A wrong open-row record or a bad address latch shows up at the very next column strobe. The bench's pin-level memory model then reads or writes the wrong word, and the following `rd_valid` returns a value that differs from the host-side shadow copy. A bad sequencing state shows up within one cycle as a strobe ordering error, a ready asserted while a column strobe is low, or a bus fight. A faulty refresh timer or debt counter shows up as a refresh gap longer than one interval plus the worst access length, or as too few refreshes over the run.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
    localparam int PIN_W  = 10;
    localparam int ADDR_W = 2 * PIN_W;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_OPEN,
        ST_PRE,
        ST_CLOSE,
        ST_REFC,
        ST_REFR
    } ctl_state_e;
endpackage

// File: rtl/edo_refresh_timer.sv
`timescale 1ns/1ps
module edo_refresh_timer #(
    parameter int REFI     = 3900,
    parameter int DEBT_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic ref_ack,
    output logic ref_req
);
    localparam int TW = $clog2(REFI + 1);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [TW-1:0] L_REFI = TW'(REFI - 1);
    localparam logic [DW-1:0] L_MAX  = DW'(DEBT_MAX);

    typedef struct packed {
        logic [TW-1:0] tick_cnt;
        logic [DW-1:0] debt;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = run_en && (q.tick_cnt == '0);
        if (!run_en || tick) d.tick_cnt = L_REFI;
        else                 d.tick_cnt = q.tick_cnt - 1'b1;
        unique case ({tick, ref_ack})
            2'b10:   if (q.debt != L_MAX) d.debt = q.debt + 1'b1;
            2'b01:   d.debt = q.debt - 1'b1;
            default: d.debt = q.debt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.tick_cnt <= L_REFI;
            q.debt     <= '0;
        end else begin
            q <= d;
        end
    end

    assign ref_req = (q.debt != '0);

    // R9
    ack_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_req);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.debt) == L_MAX && !$past(ref_ack)) |-> (q.debt == L_MAX));
endmodule

// File: rtl/edo_ctl_fsm.sv
`timescale 1ns/1ps
module edo_ctl_fsm
    import edo_pkg::*;
#(
    parameter int INIT_WAIT = 50000,
    parameter int INIT_REFS = 8,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 2,
    parameter int T_RP      = 12,
    parameter int T_CSR     = 2,
    parameter int T_RFC     = 12,
    parameter int T_RAS_MAX = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic              run_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [PIN_W-1:0]  addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int CW = $clog2(INIT_WAIT + 1) + 1;
    localparam int RW = $clog2(T_RAS_MAX + 1) + 1;
    localparam int IW = $clog2(INIT_REFS + 1) + 1;
    localparam logic [CW-1:0] L_WAIT = CW'(INIT_WAIT - 1);
    localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_CAS  = CW'(T_CAS - 1);
    localparam logic [CW-1:0] L_CP   = CW'(T_CP - 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_CSR  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_RFC  = CW'(T_RFC - 1);
    localparam logic [RW-1:0] L_RMAX = RW'(T_RAS_MAX);

    typedef struct packed {
        ctl_state_e        state;
        logic [CW-1:0]     cnt;
        logic [RW-1:0]     ras_cnt;
        logic [IW-1:0]     init_left;
        logic              init_done;
        logic [PIN_W-1:0]  row;
        logic [PIN_W-1:0]  col;
        logic              wr;
        logic [LANES-1:0]  be;
        logic              cap;
        logic              ras_n;
        logic [LANES-1:0]  cas_n;
        logic              we_n;
        logic              oe_n;
        logic [PIN_W-1:0]  addr;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctl_t;

    ctl_t q, d;
    logic hit, ras_exp, accept, in_row, cnt_zero;

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        ref_ack    = 1'b0;
        hit        = (req_addr[ADDR_W-1 -: PIN_W] == q.row);
        ras_exp    = (q.ras_cnt >= L_RMAX);
        cnt_zero   = (q.cnt == '0);
        in_row     = (q.state == ST_ACT) || (q.state == ST_PRE) ||
                     (q.state == ST_COL) || (q.state == ST_OPEN);
        unique case (q.state)
            ST_IDLE: req_ready = q.init_done && !ref_req;
            ST_OPEN: req_ready = !ref_req && !ras_exp && hit;
            default: req_ready = 1'b0;
        endcase
        accept = req_valid && req_ready;

        if (in_row && !ras_exp) d.ras_cnt = q.ras_cnt + 1'b1;
        if (!cnt_zero)          d.cnt     = q.cnt - 1'b1;

        if (accept) begin
            d.row    = req_addr[ADDR_W-1 -: PIN_W];
            d.col    = req_addr[PIN_W-1:0];
            d.wr     = req_write;
            d.be     = req_be;
            d.we_n   = !req_write;
            d.oe_n   = req_write;
            d.dq_oe  = req_write;
            d.dq_out = req_wdata;
        end

        unique case (q.state)
            ST_PWR: begin
                if (cnt_zero) d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (!q.init_done) begin
                    if (q.init_left == '0) begin
                        d.init_done = 1'b1;
                    end else begin
                        d.init_left = q.init_left - 1'b1;
                        d.state     = ST_REFC;
                    end
                end else if (ref_req) begin
                    ref_ack = 1'b1;
                    d.state = ST_REFC;
                end else if (accept) begin
                    d.state   = ST_ACT;
                    d.ras_n   = 1'b0;
                    d.addr    = req_addr[ADDR_W-1 -: PIN_W];
                    d.cnt     = L_RCD;
                    d.ras_cnt = '0;
                end
                if (d.state == ST_REFC) begin
                    d.cas_n = '0;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.addr  = '0;
                    d.cnt   = L_CSR;
                end
            end
            ST_ACT, ST_PRE: begin
                if (cnt_zero) begin
                    d.state = ST_COL;
                    d.cas_n = ~q.be;
                    d.addr  = q.col;
                    d.cnt   = L_CAS;
                end
            end
            ST_COL: begin
                if (cnt_zero) begin
                    d.state = ST_OPEN;
                    d.cas_n = '1;
                    d.cap   = !q.wr;
                    if (q.wr) begin
                        d.we_n  = 1'b1;
                        d.dq_oe = 1'b0;
                    end
                end
            end
            ST_OPEN: begin
                if (q.cap) begin
                    d.cap      = 1'b0;
                    d.rd_valid = 1'b1;
                    for (int l = 0; l < LANES; l++) begin
                        d.rd_data[l*LANE_W +: LANE_W] =
                            q.be[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
                    end
                end
                if (accept) begin
                    d.state = ST_PRE;
                    d.cnt   = L_CP;
                end else if (ref_req || ras_exp || (req_valid && !hit)) begin
                    d.state = ST_CLOSE;
                end
            end
            ST_REFC: begin
                if (cnt_zero) begin
                    d.state = ST_REFR;
                    d.ras_n = 1'b0;
                    d.cnt   = L_RFC;
                end
            end
            ST_REFR: begin
                if (cnt_zero) d.state = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (cnt_zero) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase

        if (d.state == ST_CLOSE && q.state != ST_CLOSE) begin
            d.ras_n = 1'b1;
            d.cas_n = '1;
            d.we_n  = 1'b1;
            d.oe_n  = 1'b1;
            d.dq_oe = 1'b0;
            d.cnt   = L_RP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= ST_PWR;
            q.cnt       <= L_WAIT;
            q.init_left <= IW'(INIT_REFS);
            q.ras_n     <= 1'b1;
            q.cas_n     <= '1;
            q.we_n      <= 1'b1;
            q.oe_n      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign run_en   = q.init_done;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign ras_n    = q.ras_n;
    assign cas_n    = q.cas_n;
    assign we_n     = q.we_n;
    assign oe_n     = q.oe_n;
    assign addr     = q.addr;
    assign dq_out   = q.dq_out;
    assign dq_oe    = q.dq_oe;

    // R12
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.dq_oe && !q.oe_n));
    // R5
    we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.cas_n != '1) && ($past(q.cas_n) != '1)) |-> $stable(q.we_n));
    // R10
    no_ready_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.init_done |-> !req_ready);
    // R9
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ras_n) && (q.cas_n == '0)) |-> (($past(q.cas_n) == '0) && q.we_n));
    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_valid |=> !q.rd_valid);
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int INIT_WAIT = 50000,
    parameter int INIT_REFS = 8,
    parameter int REFI      = 3900,
    parameter int DEBT_MAX  = 7,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 2,
    parameter int T_RP      = 12,
    parameter int T_CSR     = 2,
    parameter int T_RFC     = 12,
    parameter int T_RAS_MAX = 2500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [19:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        dram_ras_n,
    output logic        dram_lcas_n,
    output logic        dram_ucas_n,
    output logic        dram_we_n,
    output logic        dram_oe_n,
    output logic [9:0]  dram_addr,
    output logic [15:0] dram_dq_out,
    output logic        dram_dq_oe,
    input  logic [15:0] dram_dq_in
);
    logic             ref_req, ref_ack, run_en;
    logic [LANES-1:0] cas_n;

    edo_refresh_timer #(
        .REFI     (REFI),
        .DEBT_MAX (DEBT_MAX)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .ref_ack (ref_ack),
        .ref_req (ref_req)
    );

    edo_ctl_fsm #(
        .INIT_WAIT (INIT_WAIT),
        .INIT_REFS (INIT_REFS),
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_CP      (T_CP),
        .T_RP      (T_RP),
        .T_CSR     (T_CSR),
        .T_RFC     (T_RFC),
        .T_RAS_MAX (T_RAS_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_ready (req_ready),
        .ref_req   (ref_req),
        .ref_ack   (ref_ack),
        .run_en    (run_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ras_n     (dram_ras_n),
        .cas_n     (cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .addr      (dram_addr),
        .dq_out    (dram_dq_out),
        .dq_oe     (dram_dq_oe),
        .dq_in     (dram_dq_in)
    );

    assign dram_lcas_n = cas_n[0];
    assign dram_ucas_n = cas_n[1];
endmodule

// File: tb/edo_dram_ctrl_bench.sv
`timescale 1ns/1ps
module edo_dram_ctrl_bench;
    localparam int INIT_WAIT = 200;
    localparam int INIT_REFS = 8;
    localparam int REFI      = 300;
    localparam int DEBT_MAX  = 3;
    localparam int T_RCD     = 2;
    localparam int T_CAS     = 2;
    localparam int T_CP      = 1;
    localparam int T_RP      = 3;
    localparam int T_CSR     = 1;
    localparam int T_RFC     = 4;
    localparam int T_RAS_MAX = 40;
    localparam int RAS_BOUND = T_RAS_MAX + T_CP + T_CAS + 1;
    localparam int GAP_BOUND = REFI + RAS_BOUND + T_RP + T_CSR + T_RFC + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    always #2 clk = ~clk;

    edo_dram_ctrl #(
        .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .REFI(REFI), .DEBT_MAX(DEBT_MAX),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR),
        .T_RFC(T_RFC), .T_RAS_MAX(T_RAS_MAX)
    ) u_edo_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, failures = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // host-side shadow and expectation queues
    logic [15:0] shadow [logic [19:0]];
    logic [15:0] mem    [logic [19:0]];
    logic [22:0] acc_q [$];
    logic [15:0] exp_q [$];

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // pin-level DRAM model and monitor
    int   cyc = 0, acts = 0, refs = 0, init_refs = 0;
    int   ras_low_len = 0, ras_high_len = 0, last_ref = -1, init_cyc = 0;
    bit   init_seen = 0, cur_ref = 0, prev_rdv = 0;
    logic prev_ras = 1'b1, prev_we = 1'b1;
    logic [1:0] prev_cas = 2'b11;
    logic [9:0]  row_lat = '0;
    logic [15:0] out_reg = '0;
    logic [1:0]  out_vld = '0;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            logic [1:0]  cas, fall;
            logic [19:0] a;
            logic [22:0] e;
            logic [15:0] w;
            cyc++;
            cas  = {dram_ucas_n, dram_lcas_n};
            fall = prev_cas & ~cas;
            if (!init_seen && cyc <= INIT_WAIT && (!dram_ras_n || cas != 2'b11))
                chk(0, "R1 strobes low in power-up wait", cyc, INIT_WAIT);
            if (dram_dq_oe && !dram_oe_n) chk(0, "R12 bus fight", 1, 0);
            if (req_ready && cas != 2'b11) chk(0, "R10 ready with CAS low", cas, 2'b11);
            if (!init_seen && req_ready) begin
                chk(cyc >= INIT_WAIT, "R1 ready before wait", cyc, INIT_WAIT);
                chk(init_refs >= INIT_REFS, "R2 init refresh count", init_refs, INIT_REFS);
                init_seen = 1; init_cyc = cyc;
            end
            if (prev_ras && !dram_ras_n) begin
                chk(ras_high_len >= T_RP, "R8 RAS precharge", ras_high_len, T_RP);
                ras_high_len = 0;
                if (cas == 2'b00) begin
                    chk(prev_cas == 2'b00 && dram_we_n, "R9 CBR order", {prev_cas, dram_we_n}, 3'b001);
                    if (init_seen) begin
                        refs++;
                        chk((cyc - (last_ref < 0 ? init_cyc : last_ref)) <= GAP_BOUND,
                            "R9 refresh gap", cyc - (last_ref < 0 ? init_cyc : last_ref), GAP_BOUND);
                        last_ref = cyc;
                    end else init_refs++;
                    cur_ref = 1;
                end else begin
                    chk(cas == 2'b11, "R3 CAS high at row strobe", cas, 2'b11);
                    row_lat = dram_addr; acts++; cur_ref = 0;
                end
            end
            if (!prev_ras && dram_ras_n) begin
                if (!cur_ref) chk(ras_low_len <= RAS_BOUND, "R11 RAS low time", ras_low_len, RAS_BOUND);
                ras_low_len = 0;
            end
            if (!dram_ras_n) ras_low_len++; else ras_high_len++;
            if (!dram_ras_n && !cur_ref && prev_cas == 2'b11 && fall != 2'b00) begin
                a = {row_lat, dram_addr};
                if (acc_q.size() == 0) chk(0, "R3 unexpected access", a, 0);
                else begin
                    e = acc_q.pop_front();
                    chk(a == e[19:0], "R3 access address", a, e[19:0]);
                    chk(fall == e[21:20], "R4 lane strobes", fall, e[21:20]);
                    chk(dram_we_n == !e[22], "R6 WE level", dram_we_n, !e[22]);
                    if (e[22]) begin
                        chk(!prev_we && dram_dq_oe, "R5 write setup", {prev_we, dram_dq_oe}, 2'b01);
                        w = mem.exists(a) ? mem[a] : 16'h0;
                        if (fall[0]) w[7:0]  = dram_dq_out[7:0];
                        if (fall[1]) w[15:8] = dram_dq_out[15:8];
                        mem[a] = w;
                    end else begin
                        chk(!dram_oe_n, "R6 OE low on read", dram_oe_n, 0);
                        out_reg = mem.exists(a) ? mem[a] : 16'h0;
                        out_vld = fall;
                    end
                end
            end
            if (prev_cas != 2'b11 && cas != 2'b11 && dram_we_n != prev_we)
                chk(0, "R5 WE changed with CAS low", dram_we_n, prev_we);
            if (dram_ras_n || dram_oe_n) out_vld = '0;
            dram_dq_in[7:0]  = out_vld[0] ? out_reg[7:0]  : 8'hA5;
            dram_dq_in[15:8] = out_vld[1] ? out_reg[15:8] : 8'h5A;
            if (rd_valid) begin
                if (prev_rdv) chk(0, "R6 rd_valid pulse width", 2, 1);
                if (exp_q.size() == 0) chk(0, "R6 spurious rd_valid", rd_data, 0);
                else begin
                    w = exp_q.pop_front();
                    chk(rd_data == w, "R6 R4 read data", rd_data, w);
                end
            end
            prev_rdv = rd_valid; prev_ras = dram_ras_n; prev_cas = cas; prev_we = dram_we_n;
        end
    end

    task automatic host_req(input bit wr, input logic [19:0] a, input logic [15:0] dat,
                            input logic [1:0] be);
        logic [15:0] s;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_be = be;
        #0.5;
        while (!req_ready) begin @(negedge clk); #0.5; end
        s = shadow.exists(a) ? shadow[a] : 16'h0;
        acc_q.push_back({wr, be, a});
        if (wr) shadow[a] = (s & ~lane_mask(be)) | (dat & lane_mask(be));
        else    exp_q.push_back(s & lane_mask(be));
        @(posedge clk); #0.5;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (exp_q.size() != 0 || acc_q.size() != 0); i++) @(negedge clk);
        chk(exp_q.size() == 0 && acc_q.size() == 0, "R6 outstanding work", exp_q.size(), 0);
    endtask

    function automatic logic [19:0] ad(input int r, input int c);
        return {10'(r), 10'(c)};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int a0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R1 reset strobes", 0, 1);
        chk(!req_ready && !dram_dq_oe && !rd_valid, "R1 reset ready/bus", 1, 0);
        rst_n = 1'b1;
        while (!init_seen) @(negedge clk);

        // basic writes across rows, then reads (R3, R5, R6, R8)
        host_req(1, ad(5, 3), 16'hBEEF, 2'b11);
        host_req(1, ad(5, 4), 16'h1357, 2'b11);
        host_req(1, ad(9, 3), 16'h2468, 2'b11);
        host_req(0, ad(5, 3), 0, 2'b11);
        host_req(0, ad(5, 4), 0, 2'b11);
        host_req(0, ad(9, 3), 0, 2'b11);
        drain();

        // byte lanes (R4)
        host_req(1, ad(12, 100), 16'h1234, 2'b11);
        host_req(1, ad(12, 100), 16'hFFAB, 2'b01);
        host_req(1, ad(12, 100), 16'hCDFF, 2'b10);
        host_req(0, ad(12, 100), 0, 2'b11);
        host_req(0, ad(12, 100), 0, 2'b01);
        host_req(0, ad(12, 100), 0, 2'b10);
        drain();

        // page hits keep the row open (R7)
        host_req(0, ad(9, 3), 0, 2'b11);
        drain();
        a0 = acts; r0 = refs;
        host_req(0, ad(5, 3), 0, 2'b11);
        host_req(0, ad(5, 4), 0, 2'b11);
        host_req(0, ad(5, 3), 0, 2'b01);
        host_req(0, ad(5, 4), 0, 2'b10);
        drain();
        chk((acts - a0) >= 1 && (acts - a0) <= 1 + (refs - r0), "R7 activations in page burst",
            acts - a0, 1);

        // alternating rows reopen every time (R8)
        a0 = acts;
        host_req(0, ad(9, 3), 0, 2'b11);
        host_req(0, ad(5, 3), 0, 2'b11);
        host_req(0, ad(9, 3), 0, 2'b11);
        host_req(0, ad(5, 4), 0, 2'b11);
        drain();
        chk((acts - a0) >= 4, "R8 activations on misses", acts - a0, 4);

        // long hit run is split by the RAS limit (R11)
        a0 = acts; r0 = refs;
        for (int i = 0; i < 24; i++) host_req(1, ad(7, i), 16'(i * 16'h0111 + 16'h0F0F), 2'b11);
        for (int i = 0; i < 24; i += 5) host_req(0, ad(7, i), 0, 2'b11);
        drain();
        chk((acts - a0) >= 2, "R11 row split by RAS limit", acts - a0, 2);

        // idle interval: refreshes keep coming (R9, R10)
        r0 = refs;
        repeat (1500) @(negedge clk);
        chk((refs - r0) >= 1500 / REFI - 1, "R9 refreshes while idle", refs - r0, 1500 / REFI - 1);
        host_req(0, ad(12, 100), 0, 2'b11);
        drain();
        chk(longint'(refs) * REFI >= longint'(cyc - init_cyc - REFI - GAP_BOUND),
            "R9 overall refresh rate", refs, (cyc - init_cyc) / REFI);
        summary();
        $finish;
    end
endmodule